// File: doc/BRIEF.md
# Instruction Fetch Line Request Manager

This block sits between the fetch stage of a multi-threaded core and its instruction cache. Each thread owns one buffered cache line together with that line's aligned address. On every cycle the fetch stage may present one thread ID and fetch PC. If that thread's buffered line already covers the PC, the line is handed back in the same cycle. If it does not, the block sends a line-aligned read toward the cache over a valid/ready channel. The thread then waits for a tagged single-beat response that carries the whole line.

The cache can refuse a request. A refused request is parked in one retry register that all threads share. While that register is held, a global blocked flag stops every thread from issuing. A retry strobe from the cache resends the parked request. A squash of a thread cancels whatever that thread has outstanding, including a parked request. Each request tag holds the thread ID and a per-thread sequence bit that flips on every issue. A response that comes back after a squash, or one that belongs to nothing pending, is therefore recognised as stale, dropped and counted. While an interrupt is pending, no new line request starts for a word-aligned PC.

Top module: `fetch_line_mgr`

## Requirements
- R1: After reset every thread is idle with no valid line, `cache_blocked_o` is low, `stale_cnt_o` is zero and no request is driven.
- R2: A lookup whose thread holds a valid line at the same aligned address raises `line_ready_o` in that same cycle, presents that line on `line_data_o` and issues no request.
- R3: A missing lookup from an idle thread drives `req_valid_o` in that same cycle. `req_addr_o` is the PC with its low log2(LINE_BYTES) bits cleared. `req_tag_o` carries the thread ID in the upper bits and in bit 0 the thread's sequence bit, which is inverted on every issue. If the request is accepted, the thread shows `wait_rsp_o` from the next cycle and its line is invalid.
- R4: A request refused by the cache is parked. From the next cycle `cache_blocked_o` is high and the thread shows `wait_retry_o`. While the flag is high, no lookup from any thread drives a request.
- R5: `retry_i` with a parked request re-drives that request's address and tag in the same cycle. If it is accepted, the next cycle shows `cache_blocked_o` low and the owner in `wait_rsp_o`. If it is refused, the request stays parked.
- R6: `squash_i[t]` returns thread t to idle in the next cycle. It suppresses any issue by t in that cycle. If t owns the parked request, the parked request is discarded and `cache_blocked_o` is low in the next cycle.
- R7: A response is accepted when its thread is waiting on a response, bit 0 of its tag equals that thread's current sequence bit, and the thread is not being squashed. The line is stored and the thread becomes idle in the next cycle, so a following lookup hits.
- R8: Every response that is not accepted leaves all lines unchanged and increments `stale_cnt_o` by one in the next cycle.
- R9: While `irq_pending_i` is high, a missing lookup whose PC has bits [1:0] equal to zero issues nothing. A PC with nonzero low bits still issues, and hits are still served.
- R10: A missing lookup from a thread that is already waiting on a response or a retry issues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid_i | input | 1 | A lookup is presented this cycle |
| fetch_tid_i | input | TID_W | Thread of the lookup |
| fetch_pc_i | input | ADDR_W | Fetch PC of the lookup |
| irq_pending_i | input | 1 | Interrupt pending, holds off new requests for word-aligned PCs |
| squash_i | input | NUM_THREADS | Per-thread squash strobe |
| line_ready_o | output | 1 | Lookup hits the buffered line |
| line_data_o | output | LINE_BYTES*8 | Buffered line of the looked-up thread |
| req_valid_o | output | 1 | Read request to the cache |
| req_ready_i | input | 1 | Cache accepts the request |
| req_addr_o | output | ADDR_W | Line-aligned request address |
| req_tag_o | output | TID_W+1 | Thread ID and sequence bit |
| retry_i | input | 1 | Cache asks for the parked request again |
| rsp_valid_i | input | 1 | Response beat present |
| rsp_tag_i | input | TID_W+1 | Tag of the response |
| rsp_data_i | input | LINE_BYTES*8 | Whole line returned |
| wait_rsp_o | output | NUM_THREADS | Thread waits on a response |
| wait_retry_o | output | NUM_THREADS | Thread waits on a retry |
| cache_blocked_o | output | 1 | Retry register is held, no issue allowed |
| stale_cnt_o | output | CNT_W | Count of dropped responses |

## Verification
The request channel and the hit result are combinational, so `req_valid_o`, `req_addr_o`, `req_tag_o`, `line_ready_o` and `line_data_o` are due in the same cycle as the lookup or retry that causes them. Thread states, the blocked flag, stored lines and the stale count are registered and are due one cycle later. The bench drives every input just after the falling edge and compares the combinational outputs shortly after that. It compares the registered results only after the next rising edge, against a behavioural model that is updated at that same edge. Scenarios cover refused and retried requests, squashes that race responses and retries, interrupt hold-off on aligned and unaligned PCs, and stale tags.

// File: rtl/flm_pkg.sv
package flm_pkg;
  typedef enum logic [1:0] {
    TS_IDLE       = 2'd0,
    TS_WAIT_RSP   = 2'd1,
    TS_WAIT_RETRY = 2'd2
  } tstate_e;
endpackage

// File: rtl/flm_thread_slot.sv
module flm_thread_slot
  import flm_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LINE_BITS = 512
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 issue_i,
  input  logic                 issue_acc_i,
  input  logic [ADDR_W-1:0]    issue_addr_i,
  input  logic                 promote_i,
  input  logic                 rsp_take_i,
  input  logic [LINE_BITS-1:0] rsp_data_i,
  input  logic                 squash_i,
  output tstate_e              state_o,
  output logic                 valid_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic                 seq_o,
  output logic [LINE_BITS-1:0] data_o
);
  tstate_e             state_q, state_n;
  logic                valid_q, valid_n;
  logic [ADDR_W-1:0]   addr_q, addr_n;
  logic                seq_q, seq_n;
  logic                data_en;
  logic [LINE_BITS-1:0] data_q;

  always_comb begin
    state_n = state_q;
    valid_n = valid_q;
    addr_n  = addr_q;
    seq_n   = seq_q;
    data_en = 1'b0;
    if (squash_i) begin
      state_n = TS_IDLE;
    end else if (issue_i) begin
      addr_n  = issue_addr_i;
      valid_n = 1'b0;
      seq_n   = ~seq_q;
      state_n = issue_acc_i ? TS_WAIT_RSP : TS_WAIT_RETRY;
    end else if (promote_i) begin
      state_n = TS_WAIT_RSP;
    end else if (rsp_take_i) begin
      valid_n = 1'b1;
      state_n = TS_IDLE;
      data_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TS_IDLE;
      valid_q <= 1'b0;
      addr_q  <= '0;
      seq_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      valid_q <= valid_n;
      addr_q  <= addr_n;
      seq_q   <= seq_n;
    end
  end

  always_ff @(posedge clk) begin
    if (data_en) data_q <= rsp_data_i;
  end

  assign state_o = state_q;
  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign seq_o   = seq_q;
  assign data_o  = data_q;

  // R3
  wait_rsp_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == TS_WAIT_RSP |-> !valid_q);
  // R6
  squash_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    squash_i |=> state_q == TS_IDLE);
  // R7
  rsp_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take_i && !squash_i |=> valid_q && state_q == TS_IDLE);
endmodule

// File: rtl/flm_retry_slot.sv
module flm_retry_slot #(
  parameter int ADDR_W = 32,
  parameter int TID_W  = 1,
  parameter int TAG_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              park_i,
  input  logic [TID_W-1:0]  park_tid_i,
  input  logic [ADDR_W-1:0] park_addr_i,
  input  logic [TAG_W-1:0]  park_tag_i,
  input  logic              owner_squash_i,
  input  logic              resend_acc_i,
  input  logic              retry_i,
  output logic              slot_v_o,
  output logic [TID_W-1:0]  slot_tid_o,
  output logic [ADDR_W-1:0] slot_addr_o,
  output logic [TAG_W-1:0]  slot_tag_o,
  output logic              blocked_o
);
  logic              v_q, v_n, blk_q, blk_n, load;
  logic [TID_W-1:0]  tid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [TAG_W-1:0]  tag_q;

  always_comb begin
    v_n   = v_q;
    blk_n = blk_q;
    load  = 1'b0;
    if (park_i) begin
      v_n   = 1'b1;
      blk_n = 1'b1;
      load  = 1'b1;
    end else if (owner_squash_i || resend_acc_i) begin
      v_n   = 1'b0;
      blk_n = 1'b0;
    end else if (retry_i && !v_q) begin
      blk_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      blk_q  <= 1'b0;
      tid_q  <= '0;
      addr_q <= '0;
      tag_q  <= '0;
    end else begin
      v_q   <= v_n;
      blk_q <= blk_n;
      if (load) begin
        tid_q  <= park_tid_i;
        addr_q <= park_addr_i;
        tag_q  <= park_tag_i;
      end
    end
  end

  assign slot_v_o    = v_q;
  assign slot_tid_o  = tid_q;
  assign slot_addr_o = addr_q;
  assign slot_tag_o  = tag_q;
  assign blocked_o   = blk_q;

  // R4
  slot_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_q |-> blk_q);
  // R6
  squash_unblock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    owner_squash_i |=> !blk_q && !v_q);
  // R5
  resend_unblock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resend_acc_i && !owner_squash_i |=> !blk_q);
endmodule

// File: rtl/fetch_line_mgr.sv
module fetch_line_mgr
  import flm_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 64,
  parameter int CNT_W       = 16,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int TAG_W      = TID_W + 1,
  localparam int LINE_BITS  = LINE_BYTES * 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fetch_valid_i,
  input  logic [TID_W-1:0]       fetch_tid_i,
  input  logic [ADDR_W-1:0]      fetch_pc_i,
  input  logic                   irq_pending_i,
  input  logic [NUM_THREADS-1:0] squash_i,
  output logic                   line_ready_o,
  output logic [LINE_BITS-1:0]   line_data_o,
  output logic                   req_valid_o,
  input  logic                   req_ready_i,
  output logic [ADDR_W-1:0]      req_addr_o,
  output logic [TAG_W-1:0]       req_tag_o,
  input  logic                   retry_i,
  input  logic                   rsp_valid_i,
  input  logic [TAG_W-1:0]       rsp_tag_i,
  input  logic [LINE_BITS-1:0]   rsp_data_i,
  output logic [NUM_THREADS-1:0] wait_rsp_o,
  output logic [NUM_THREADS-1:0] wait_retry_o,
  output logic                   cache_blocked_o,
  output logic [CNT_W-1:0]       stale_cnt_o
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  tstate_e              thr_state [NUM_THREADS];
  logic                 thr_valid [NUM_THREADS];
  logic [ADDR_W-1:0]    thr_addr  [NUM_THREADS];
  logic                 thr_seq   [NUM_THREADS];
  logic [LINE_BITS-1:0] thr_data  [NUM_THREADS];

  logic              slot_v, blocked;
  logic [TID_W-1:0]  slot_tid;
  logic [ADDR_W-1:0] slot_addr;
  logic [TAG_W-1:0]  slot_tag;

  logic [ADDR_W-1:0] aligned_pc;
  logic              hit, irq_hold, new_issue, resend, rsp_take;
  logic [TID_W-1:0]  rsp_tid;
  logic [CNT_W-1:0]  cnt_q, cnt_n;

  always_comb begin
    aligned_pc = {fetch_pc_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    hit        = fetch_valid_i && thr_valid[fetch_tid_i]
                 && (thr_addr[fetch_tid_i] == aligned_pc);
    irq_hold   = irq_pending_i && (fetch_pc_i[1:0] == 2'b00);
    new_issue  = fetch_valid_i && !hit && (thr_state[fetch_tid_i] == TS_IDLE)
                 && !blocked && !irq_hold && !squash_i[fetch_tid_i];
    resend     = retry_i && slot_v && !squash_i[slot_tid];
    rsp_tid    = rsp_tag_i[TAG_W-1:1];
    rsp_take   = rsp_valid_i && (thr_state[rsp_tid] == TS_WAIT_RSP)
                 && (rsp_tag_i[0] == thr_seq[rsp_tid]) && !squash_i[rsp_tid];
    cnt_n      = (rsp_valid_i && !rsp_take) ? cnt_q + CNT_W'(1) : cnt_q;
  end

  assign req_valid_o  = new_issue || resend;
  assign req_addr_o   = resend ? slot_addr : aligned_pc;
  assign req_tag_o    = resend ? slot_tag : {fetch_tid_i, ~thr_seq[fetch_tid_i]};
  assign line_ready_o = hit;
  assign line_data_o  = thr_data[fetch_tid_i];

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    flm_thread_slot #(.ADDR_W(ADDR_W), .LINE_BITS(LINE_BITS)) u_slot (
      .clk          (clk),
      .rst_n        (rst_n),
      .issue_i      (new_issue && (fetch_tid_i == TID_W'(t))),
      .issue_acc_i  (req_ready_i),
      .issue_addr_i (aligned_pc),
      .promote_i    (resend && req_ready_i && (slot_tid == TID_W'(t))),
      .rsp_take_i   (rsp_take && (rsp_tid == TID_W'(t))),
      .rsp_data_i   (rsp_data_i),
      .squash_i     (squash_i[t]),
      .state_o      (thr_state[t]),
      .valid_o      (thr_valid[t]),
      .addr_o       (thr_addr[t]),
      .seq_o        (thr_seq[t]),
      .data_o       (thr_data[t])
    );
    assign wait_rsp_o[t]   = (thr_state[t] == TS_WAIT_RSP);
    assign wait_retry_o[t] = (thr_state[t] == TS_WAIT_RETRY);
  end

  flm_retry_slot #(.ADDR_W(ADDR_W), .TID_W(TID_W), .TAG_W(TAG_W)) u_retry (
    .clk            (clk),
    .rst_n          (rst_n),
    .park_i         (new_issue && !req_ready_i),
    .park_tid_i     (fetch_tid_i),
    .park_addr_i    (aligned_pc),
    .park_tag_i     ({fetch_tid_i, ~thr_seq[fetch_tid_i]}),
    .owner_squash_i (slot_v && squash_i[slot_tid]),
    .resend_acc_i   (resend && req_ready_i),
    .retry_i        (retry_i),
    .slot_v_o       (slot_v),
    .slot_tid_o     (slot_tid),
    .slot_addr_o    (slot_addr),
    .slot_tag_o     (slot_tag),
    .blocked_o      (blocked)
  );

  assign cache_blocked_o = blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign stale_cnt_o = cnt_q;

  // R4
  blocked_no_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cache_blocked_o && !retry_i |-> !req_valid_o);
  // R2
  hit_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_ready_o && !retry_i |-> !req_valid_o);
  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending_i && fetch_pc_i[1:0] == 2'b00 && !retry_i |-> !req_valid_o);
  // R8
  stale_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_i && !rsp_take |=> stale_cnt_o == $past(stale_cnt_o) + CNT_W'(1));
  // R3
  req_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> req_addr_o[OFF_W-1:0] == '0);
endmodule

// File: tb/fetch_line_mgr_test.sv
module fetch_line_mgr_test;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 2;
  localparam int LB = 512;

  logic clk = 1'b0;
  logic rst_n;
  logic fv, irq, rdy, rty, rv;
  logic [0:0] tid;
  logic [31:0] pc;
  logic [1:0] sq, rtag;
  logic [LB-1:0] rdata;
  logic lready, reqv, blk;
  logic [LB-1:0] ldata;
  logic [31:0] raddr;
  logic [1:0] rqtag, wrsp, wrty;
  logic [15:0] scnt;

  int checks = 0, errors = 0;
  string cur_r = "R1";

  // behavioural model
  int m_st [NT];
  bit m_v [NT];
  logic [31:0] m_a [NT];
  bit m_seq [NT];
  logic [LB-1:0] m_d [NT];
  bit s_v, m_blk;
  int s_tid, m_cnt;
  logic [31:0] s_a;
  logic [1:0] s_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_line_mgr uut (
    .clk(clk), .rst_n(rst_n), .fetch_valid_i(fv), .fetch_tid_i(tid),
    .fetch_pc_i(pc), .irq_pending_i(irq), .squash_i(sq),
    .line_ready_o(lready), .line_data_o(ldata), .req_valid_o(reqv),
    .req_ready_i(rdy), .req_addr_o(raddr), .req_tag_o(rqtag), .retry_i(rty),
    .rsp_valid_i(rv), .rsp_tag_i(rtag), .rsp_data_i(rdata),
    .wait_rsp_o(wrsp), .wait_retry_o(wrty), .cache_blocked_o(blk),
    .stale_cnt_o(scnt)
  );

  task automatic chk(input string r, input string what, input logic [LB-1:0] act, input logic [LB-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic idle_in();
    fv = 0; tid = 0; pc = 0; irq = 0; sq = 0; rdy = 1; rty = 0; rv = 0; rtag = 0; rdata = '0;
  endtask

  function automatic logic [LB-1:0] pat(input int n);
    return {16{32'hA1A1_0000 + n}};
  endfunction

  // one clock: compare same-cycle outputs, then registered ones after the edge
  task automatic cycle();
    logic [31:0] al;
    int t, rt;
    bit e_hit, e_iss, e_res, e_take, own_sq;
    logic [1:0] e_tag;
    #1;
    t = int'(tid);
    al = pc & ~32'h3f;
    e_hit = fv && m_v[t] && m_a[t] == al;
    e_iss = fv && !e_hit && m_st[t] == 0 && !m_blk && !(irq && pc[1:0] == 2'b00) && !sq[t];
    e_res = rty && s_v && !sq[s_tid];
    e_tag = {tid, ~m_seq[t]};
    chk(cur_r, "req_valid", LB'(reqv), LB'(e_iss || e_res));
    if (e_res) begin
      chk(cur_r, "req_addr(resend)", LB'(raddr), LB'(s_a));
      chk(cur_r, "req_tag(resend)", LB'(rqtag), LB'(s_tag));
    end else if (e_iss) begin
      chk(cur_r, "req_addr", LB'(raddr), LB'(al));
      chk(cur_r, "req_tag", LB'(rqtag), LB'(e_tag));
    end
    chk(cur_r, "line_ready", LB'(lready), LB'(e_hit));
    if (e_hit) chk(cur_r, "line_data", ldata, m_d[t]);
    rt = int'(rtag[1]);
    e_take = rv && m_st[rt] == 1 && rtag[0] == m_seq[rt] && !sq[rt];
    own_sq = s_v && sq[s_tid];
    @(posedge clk);
    for (int k = 0; k < NT; k++) if (sq[k]) m_st[k] = 0;
    if (e_iss) begin
      m_a[t] = al; m_v[t] = 0; m_seq[t] = ~m_seq[t];
      m_st[t] = rdy ? 1 : 2;
      if (!rdy) begin s_v = 1; s_tid = t; s_a = al; s_tag = e_tag; m_blk = 1; end
    end else if (own_sq) begin
      s_v = 0; m_blk = 0;
    end else if (e_res && rdy) begin
      m_st[s_tid] = 1; s_v = 0; m_blk = 0;
    end else if (rty && !s_v) begin
      m_blk = 0;
    end
    if (e_take) begin m_v[rt] = 1; m_d[rt] = rdata; m_st[rt] = 0; end
    else if (rv) m_cnt++;
    #1;
    for (int k = 0; k < NT; k++) begin
      chk(cur_r, "wait_rsp", LB'(wrsp[k]), LB'(m_st[k] == 1));
      chk(cur_r, "wait_retry", LB'(wrty[k]), LB'(m_st[k] == 2));
    end
    chk(cur_r, "cache_blocked", LB'(blk), LB'(m_blk));
    chk(cur_r, "stale_cnt", LB'(scnt), LB'(m_cnt[15:0]));
    @(negedge clk);
    idle_in();
  endtask

  task automatic lookup(input int t, input logic [31:0] p, input logic r);
    fv = 1; tid = 1'(t); pc = p; rdy = r; cycle();
  endtask

  task automatic respond(input logic [1:0] tg, input int n);
    rv = 1; rtag = tg; rdata = pat(n); cycle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle_in();
    for (int k = 0; k < NT; k++) begin m_st[k] = 0; m_v[k] = 0; m_a[k] = 0; m_seq[k] = 0; m_d[k] = '0; end
    s_v = 0; m_blk = 0; s_tid = 0; m_cnt = 0; s_a = 0; s_tag = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1", "req_valid", LB'(reqv), '0);
    chk("R1", "cache_blocked", LB'(blk), '0);
    chk("R1", "wait_rsp", LB'(wrsp), '0);
    chk("R1", "wait_retry", LB'(wrty), '0);
    chk("R1", "stale_cnt", LB'(scnt), '0);
    chk("R1", "line_ready", LB'(lready), '0);
    @(negedge clk);

    cur_r = "R3"; lookup(0, 32'h1004, 1);
    chk("R3", "wait_rsp t0", LB'(wrsp[0]), LB'(1));
    cur_r = "R10"; lookup(0, 32'h1010, 1);
    cur_r = "R7"; respond(2'b01, 1);
    cur_r = "R2"; lookup(0, 32'h1038, 1);
    chk("R2", "hit data", ldata, pat(1));
    cur_r = "R8"; respond(2'b01, 2);
    respond(2'b10, 3);
    chk("R8", "stale count", LB'(scnt), LB'(2));
    cur_r = "R2"; lookup(0, 32'h1000, 1);

    cur_r = "R4"; lookup(1, 32'h2010, 0);
    chk("R4", "blocked", LB'(blk), LB'(1));
    lookup(0, 32'h3000, 1);
    cur_r = "R5"; rty = 1; rdy = 0; cycle();
    chk("R5", "still blocked", LB'(blk), LB'(1));
    rty = 1; rdy = 1; cycle();
    chk("R5", "wait_rsp t1", LB'(wrsp[1]), LB'(1));
    cur_r = "R7"; respond(2'b11, 4);
    lookup(1, 32'h2020, 1);

    cur_r = "R6"; lookup(1, 32'h4000, 0);
    sq = 2'b10; cycle();
    chk("R6", "unblocked", LB'(blk), LB'(0));
    rty = 1; cycle();
    lookup(0, 32'h5000, 1);
    sq = 2'b01; cycle();
    cur_r = "R8"; respond(2'b00, 5);
    cur_r = "R3"; lookup(0, 32'h5000, 1);
    cur_r = "R8"; respond(2'b00, 6);
    cur_r = "R7"; respond(2'b01, 7);
    cur_r = "R6"; fv = 1; tid = 1; pc = 32'h7000; sq = 2'b10; cycle();
    chk("R6", "no issue on squash", LB'(wrsp[1] | wrty[1]), '0);
    // squash racing a correct response
    lookup(1, 32'h7000, 1);
    rv = 1; rtag = 2'b11; rdata = pat(8); sq = 2'b10; cycle();

    cur_r = "R9"; irq = 1; lookup(1, 32'h6000, 1);
    chk("R9", "no wait after hold", LB'(wrsp[1]), '0);
    irq = 1; lookup(1, 32'h6002, 1);
    irq = 1; lookup(0, 32'h5008, 1);
    cur_r = "R10"; lookup(1, 32'h6100, 1);
    cur_r = "R7"; respond(2'b10, 9);
    lookup(1, 32'h6004, 1);
    repeat (2) cycle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule